// File: doc/BRIEF.md
# Linked-List Command Fetch Engine

This block follows a chain of command blocks stored in system memory and passes their payload words, one at a time, to a downstream command parser. Every node begins with a single header word. The top byte of that word gives the number of payload words that follow the header. The low 24 bits give the address of the next node. The engine reads the header, then reads the payload words at increasing addresses and hands each one downstream. It then moves to the next node. Walking stops when the current node address has its bit 23 set.

While it walks, the engine keeps an estimate of the processing cost of the list. Each node adds a fixed amount. A node that carries payload adds a further fixed amount plus its length. The total stays on an output once the walk has finished.

The memory side uses a single read port addressed in 32-bit words. It has a one-cycle request strobe and a response valid that may come back after any latency. At most one read is outstanding at any time.

Top module: `cmd_chain_walker`

## Requirements
- R1: After reset, `busy`, `done`, `out_valid` and `mem_req` are low and `cost_total` is zero.
- R2: Only the low 24 bits of `start_addr` are used; bits 31:24 of it have no effect on the walk.
- R3: A header word carries the payload length in bits 31:24 and the next node address in bits 23:0.
- R4: Every memory read uses the byte address masked to 21 bits; `mem_addr` carries bits 20:2 of that address.
- R5: The payload words of a node are read and emitted in ascending address order, starting at the header's byte address plus 4.
- R6: A node with length 0 emits no payload word but still continues to its next address.
- R7: The walk ends, with no further memory read, as soon as the current node address has bit 23 set; this includes a start address with bit 23 set.
- R8: `cost_total` is cleared at start and grows by 10 for every node, plus 5 + length for every node with non-zero length; it stays unchanged while idle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R10: `done` is high for exactly one cycle at termination, with `busy` high in that cycle; `busy` is high from the cycle after `start` is sampled up to and including the `done` cycle.
- R11: A `start` pulse while `busy` is high is ignored; the walk in progress is unaffected.
- R12: `mem_req` is a single-cycle strobe, and a new request is issued only after the previous read has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk at `start_addr` (sampled only when idle) |
| start_addr | input | 32 | Byte address of the first node |
| mem_req | output | 1 | Read request strobe |
| mem_addr | output | 19 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Payload word available |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Downstream accepts the word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle termination pulse |
| cost_total | output | 32 | Accumulated cost estimate |

## Verification
The bench uses the default parameters: 32-bit words, an 8-bit length field, a 24-bit link field and a 21-bit memory mask. These defaults allow a maximum-length node of 255 payload words. They also make it possible to write links and start addresses with bits above the mask set, so the bench can check that those addresses alias onto low memory. A behavioural model walks the same memory image and places the expected read addresses and payload words in queues. Each request and each accepted beat is compared against these queues on every clock, under zero and multi-cycle read latency and with a stalling downstream.

// File: rtl/cmd_chain_pkg.sv
package cmd_chain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_HREQ, ST_HWAIT, ST_PREQ, ST_PWAIT, ST_SEND, ST_DONE
  } walk_st_t;
endpackage

// File: rtl/cmd_chain_hdr.sv
module cmd_chain_hdr #(
  parameter int WORD_W    = 32,
  parameter int LEN_W     = 8,
  parameter int PTR_W     = 24,
  parameter int CYC_W     = 32,
  parameter int NODE_COST = 10,
  parameter int LEN_COST  = 5
) (
  input  logic [WORD_W-1:0] hdr_word,
  output logic [LEN_W-1:0]  hdr_len,
  output logic [PTR_W-1:0]  hdr_next,
  output logic [CYC_W-1:0]  hdr_cost
);
  assign hdr_len  = hdr_word[WORD_W-1 -: LEN_W];
  assign hdr_next = hdr_word[PTR_W-1:0];

  always_comb begin
    if (hdr_len == '0)
      hdr_cost = CYC_W'(NODE_COST);
    else
      hdr_cost = CYC_W'(NODE_COST + LEN_COST) + CYC_W'(hdr_len);
  end
endmodule

// File: rtl/cmd_chain_cost.sv
module cmd_chain_cost #(
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_en,
  input  logic [CYC_W-1:0] add_val,
  output logic [CYC_W-1:0] total
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      total <= '0;
    else if (add_en)
      total <= total + add_val;
  end
endmodule

// File: rtl/cmd_chain_outreg.sv
module cmd_chain_outreg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] dout,
  output logic              fire
);
  assign fire = valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (fire) begin
      valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(dout))); // R9
endmodule

// File: rtl/cmd_chain_walker.sv
module cmd_chain_walker
  import cmd_chain_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int LEN_W     = 8,
  parameter int PTR_W     = 24,
  parameter int ADDR_W    = 21,
  parameter int CYC_W     = 32,
  parameter int NODE_COST = 10,
  parameter int LEN_COST  = 5,
  localparam int WADDR_W  = ADDR_W - 2,
  localparam int END_BIT  = PTR_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WORD_W-1:0]  start_addr,
  output logic               mem_req,
  output logic [WADDR_W-1:0] mem_addr,
  input  logic               mem_rvalid,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_data,
  input  logic               out_ready,
  output logic               busy,
  output logic               done,
  output logic [CYC_W-1:0]   cost_total
);
  walk_st_t           state;
  logic [PTR_W-1:0]   cur_ptr;
  logic [PTR_W-1:0]   nxt_ptr;
  logic [ADDR_W-1:0]  rd_ptr;
  logic [LEN_W-1:0]   remain;

  logic [LEN_W-1:0]   hdr_len;
  logic [PTR_W-1:0]   hdr_next;
  logic [CYC_W-1:0]   hdr_cost;
  logic               hdr_take;
  logic               pay_take;
  logic               beat_fire;
  logic               cost_clr;

  cmd_chain_hdr #(
    .WORD_W(WORD_W), .LEN_W(LEN_W), .PTR_W(PTR_W), .CYC_W(CYC_W),
    .NODE_COST(NODE_COST), .LEN_COST(LEN_COST)
  ) i_hdr (
    .hdr_word(mem_rdata),
    .hdr_len (hdr_len),
    .hdr_next(hdr_next),
    .hdr_cost(hdr_cost)
  );

  assign hdr_take = (state == ST_HWAIT) && mem_rvalid;
  assign pay_take = (state == ST_PWAIT) && mem_rvalid;
  assign cost_clr = (state == ST_IDLE) && start;

  cmd_chain_cost #(.CYC_W(CYC_W)) i_cost (
    .clk    (clk),
    .rst    (rst),
    .clr    (cost_clr),
    .add_en (hdr_take),
    .add_val(hdr_cost),
    .total  (cost_total)
  );

  cmd_chain_outreg #(.WORD_W(WORD_W)) i_out (
    .clk  (clk),
    .rst  (rst),
    .load (pay_take),
    .din  (mem_rdata),
    .ready(out_ready),
    .valid(out_valid),
    .dout (out_data),
    .fire (beat_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cur_ptr <= '0;
      nxt_ptr <= '0;
      rd_ptr  <= '0;
      remain  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          cur_ptr <= start_addr[PTR_W-1:0];
          state   <= ST_CHECK;
        end
        ST_CHECK: state <= cur_ptr[END_BIT] ? ST_DONE : ST_HREQ;
        ST_HREQ:  state <= ST_HWAIT;
        ST_HWAIT: if (mem_rvalid) begin
          nxt_ptr <= hdr_next;
          remain  <= hdr_len;
          rd_ptr  <= cur_ptr[ADDR_W-1:0] + ADDR_W'(4);
          if (hdr_len == '0) begin
            cur_ptr <= hdr_next;
            state   <= ST_CHECK;
          end else begin
            state   <= ST_PREQ;
          end
        end
        ST_PREQ:  state <= ST_PWAIT;
        ST_PWAIT: if (mem_rvalid) state <= ST_SEND;
        ST_SEND: if (beat_fire) begin
          remain <= remain - LEN_W'(1);
          rd_ptr <= rd_ptr + ADDR_W'(4);
          if (remain == LEN_W'(1)) begin
            cur_ptr <= nxt_ptr;
            state   <= ST_CHECK;
          end else begin
            state   <= ST_PREQ;
          end
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req  = (state == ST_HREQ) || (state == ST_PREQ);
  assign mem_addr = (state == ST_HREQ) ? cur_ptr[ADDR_W-1:2] : rd_ptr[ADDR_W-1:2];
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> busy); // R10
  AST_REQ_STROBE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !out_valid && !done)); // R1
  AST_TERM_STOP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHECK && cur_ptr[END_BIT]) |=> (done && !mem_req)); // R7
  AST_COST_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(cost_total)); // R8
  AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy); // R11
endmodule

// File: tb/test_cmd_chain_walker.sv
module test_cmd_chain_walker;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        mem_req;
  logic [18:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;
  logic        busy;
  logic        done;
  logic [31:0] cost_total;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_chain_walker i_cmd_chain_walker (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .busy(busy), .done(done), .cost_total(cost_total)
  );

  logic [31:0] mem [0:MEM_WORDS-1];
  logic [18:0] q_addr[$];
  logic [31:0] q_data[$];
  int unsigned exp_cost;
  int n_cmp = 0;
  int n_bad = 0;
  int lat = 0;
  int rmode = 0;
  int n_done = 0;
  int cyc_n = 0;
  int pend = 0;
  int cnt = 0;
  logic [18:0] pend_addr = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: walk the memory image
  task automatic ref_walk(input logic [31:0] sa);
    logic [31:0] a;
    logic [31:0] h;
    logic [31:0] p;
    int len;
    int guard;
    a = sa & 32'h00FF_FFFF;
    exp_cost = 0;
    guard = 0;
    while (a[23] == 1'b0 && guard < 64) begin
      p = a & 32'h001F_FFFF;
      q_addr.push_back(p[20:2]);
      h = mem[p[13:2]];
      len = int'(h[31:24]);
      exp_cost += 10;
      if (len != 0) exp_cost += 5 + len;
      for (int i = 0; i < len; i++) begin
        p = (p + 4) & 32'h001F_FFFF;
        q_addr.push_back(p[20:2]);
        q_data.push_back(mem[p[13:2]]);
      end
      a = h & 32'h00FF_FFFF;
      guard++;
    end
  endtask

  // memory, downstream and comparison process
  always @(negedge clk) begin
    cyc_n++;
    if (rst) begin
      mem_rvalid = 1'b0;
      pend = 0;
    end else begin
      mem_rvalid = 1'b0;
      if (pend == 1) begin
        if (cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem[pend_addr[11:0]];
          pend = 0;
        end else cnt--;
      end
      if (mem_req) begin
        chk(pend == 0, "R12 one outstanding", pend, 0);
        if (q_addr.size() == 0) chk(1'b0, "R7 unexpected read", mem_addr, 0);
        else chk(mem_addr == q_addr[0], "R4/R5 read address", mem_addr, q_addr[0]);
        if (q_addr.size() != 0) void'(q_addr.pop_front());
        pend = 1;
        cnt = lat;
        pend_addr = mem_addr;
      end
      out_ready = (rmode == 0) ? 1'b1 : ((cyc_n % 3) != 0);
      if (out_valid && out_ready) begin
        if (q_data.size() == 0) chk(1'b0, "R6 unexpected beat", out_data, 0);
        else begin
          chk(out_data == q_data[0], "R5/R9 payload word", out_data, q_data[0]);
          void'(q_data.pop_front());
        end
      end
      if (done) begin
        n_done++;
        chk(cost_total == exp_cost, "R8 cost total", cost_total, exp_cost);
      end
    end
  end

  task automatic run(input logic [31:0] sa, input int l, input int rm,
                     input bit poke, input logic [31:0] poke_addr);
    int t;
    lat = l;
    rmode = rm;
    n_done = 0;
    ref_walk(sa);
    @(negedge clk);
    start = 1'b1;
    start_addr = sa;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    t = 0;
    while (n_done == 0 && t < 5000) begin
      @(negedge clk);
      t++;
      if (poke && t == 6) begin
        start = 1'b1;
        start_addr = poke_addr;
      end else start = 1'b0;
    end
    chk(t < 5000, "R10 watchdog", t, 0);
    @(negedge clk);
    @(negedge clk);
    chk(n_done == 1, "R10 single done", n_done, 1);
    chk(busy == 1'b0, "R10 idle after done", busy, 0);
    chk(q_addr.size() == 0, "R7 all reads made", q_addr.size(), 0);
    chk(q_data.size() == 0, "R6 all beats seen", q_data.size(), 0);
    q_addr.delete();
    q_data.delete();
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'hA500_0000 ^ i;
    // single node, length 3 at 0x100
    mem[12'h040] = {8'd3, 24'h80_0000};
    // chain 0x200 -> 0x300 (len 0) -> 0x400 -> end
    mem[12'h080] = {8'd2, 24'h00_0300};
    mem[12'h0C0] = {8'd0, 24'h00_0400};
    mem[12'h100] = {8'd1, 24'hFF_FFFF};
    // aliasing: 0x40 links to 0x600080 which masks to 0x80
    mem[12'h010] = {8'd2, 24'h60_0080};
    mem[12'h020] = {8'd1, 24'h80_0000};
    // maximum length node at 0x1000
    mem[12'h400] = {8'd255, 24'h80_0000};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !out_valid && !mem_req, "R1 reset outputs",
        {busy, done, out_valid, mem_req}, 0);
    chk(cost_total == 0, "R1 reset cost", cost_total, 0);

    run(32'h0000_0100, 0, 0, 1'b0, '0);          // R3 R5 R8
    run(32'h0000_0200, 2, 0, 1'b0, '0);          // R6
    run(32'h0080_0000, 0, 0, 1'b0, '0);          // R7 immediate end
    chk(cost_total == 0, "R7 no node cost", cost_total, 0);
    run(32'h5F00_0040, 1, 0, 1'b0, '0);          // R2 R4
    run(32'h0000_0100, 3, 1, 1'b0, '0);          // R9 stalls
    run(32'h0000_0200, 1, 1, 1'b1, 32'h0000_0100); // R11
    run(32'h0000_1000, 0, 1, 1'b0, '0);          // R8 max length
    chk(cost_total == 32'd270, "R8 max length cost", cost_total, 270);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule